// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a memory-mapped countdown timer with a 32-bit prescaler. Software writes a reload value for the prescaler and a starting count while the timer is idle. A write to the control register then starts it. While it runs, a prescale counter steps down once per clock. Each time that counter passes zero, it reloads and the timer count drops by one. When the count reaches zero, the timer stops by itself and reports itself ready again.

The control register toggles the run state. A write while idle starts the timer, and a write while running stops it. A stopped timer holds its count, which software can read or replace. While the timer runs, the configuration registers are locked, and the timer register returns the live count. The register interface is a single-cycle write strobe with a word index, and read data is combinational. A `running` output mirrors the run state for neighbouring logic.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: After reset the timer is idle: `running` is 0, status bit 0 reads 1, and the prescaler and timer registers read 0.
- R2: Registers are selected by `addr`: 0 is control (reads 0), 1 is status (bit 0 = ready, other bits 0), 2 is prescaler, 3 is timer. While idle, writes to prescaler and timer take effect on the next cycle and read back unchanged.
- R3: A write to control while idle starts the timer whatever the data value: from the next cycle `running` is 1 and status bit 0 reads 0.
- R4: A write to control while running stops the timer on the next cycle. The count is frozen at its value with no decrement in that cycle, and it can then be read back and overwritten.
- R5: While running, writes to the prescaler and timer registers are ignored; both keep their values.
- R6: With prescaler value P, the timer count decrements once every P+1 clocks while running, and the first decrement comes P+1 clocks after the start write.
- R7: When the count decrements to zero, `running` falls in that same cycle, status bit 0 returns to 1, and the timer register reads 0.
- R8: Starting with a timer value of 0 runs for exactly one cycle and then returns to idle with the count still 0.
- R9: While running, reading the timer register returns the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| running | output | 1 | High while the timer counts down |

## Verification
The countdown is tried with prescaler values of 0, 1 and 2, and with several starting counts. Mid-run reads of the live count pin down the exact cycle of each decrement, which separates a P+1 period from a P or P+2 period. A stop partway through a run checks that the stop write beats a tick in the same cycle and that the frozen count can be replaced. A start from a zero count, and configuration writes made while running, probe the lockout and the edge case at zero.

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              running
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_PRE  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] pre_q, pre_cnt, cnt_q;
  logic run_q;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire pre_wr  = wr_en && addr == A_PRE && !run_q;
  wire cnt_wr  = wr_en && addr == A_CNT && !run_q;
  wire tick    = run_q && pre_cnt == ZERO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pre_q   <= ZERO;
      pre_cnt <= ZERO;
      cnt_q   <= ZERO;
    end else begin
      if (pre_wr) pre_q <= wdata;
      if (cnt_wr) cnt_q <= wdata;
      if (!run_q) begin
        if (ctrl_wr) begin
          run_q   <= 1'b1;
          pre_cnt <= pre_q;
        end
      end else if (ctrl_wr) begin
        run_q <= 1'b0;
      end else if (cnt_q == ZERO) begin
        run_q <= 1'b0;
      end else if (tick) begin
        pre_cnt <= pre_q;
        cnt_q   <= cnt_q - ONE;
        if (cnt_q == ONE) run_q <= 1'b0;
      end else begin
        pre_cnt <= pre_cnt - ONE;
      end
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = {{(DATA_W-1){1'b0}}, !run_q};
      A_PRE:   rdata = pre_q;
      A_CNT:   rdata = cnt_q;
      default: rdata = ZERO;
    endcase
  end

  assign running = run_q;
endmodule

// File: rtl/prescaled_countdown_timer_chk.sv
module prescaled_countdown_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              running,
  input logic [DATA_W-1:0] pre_q,
  input logic [DATA_W-1:0] pre_cnt,
  input logic [DATA_W-1:0] cnt_q
);
  // R3
  start_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && wr_en && addr == 2'd0) |=> running);
  // R4
  stop_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && addr == 2'd0) |=> (!running && cnt_q == $past(cnt_q)));
  // R5
  pre_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(pre_q));
  // R6
  count_never_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> cnt_q <= $past(cnt_q));
  // R6
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pre_cnt <= pre_q);
  // R7
  zero_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_q == '0) |=> !running);
endmodule

bind prescaled_countdown_timer prescaled_countdown_timer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .running(run_q),
  .pre_q(pre_q), .pre_cnt(pre_cnt), .cnt_q(cnt_q)
);

// File: tb/prescaled_countdown_timer_tb_top.sv
module prescaled_countdown_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic running;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  prescaled_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .running(running)
  );

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_state(string req, logic exp_run, logic [31:0] exp_cnt);
    logic [31:0] v;
    expect_eq(req, "running", {31'b0, running}, {31'b0, exp_run});
    rd(2'd1, v);
    expect_eq(req, "status", v, {31'b0, !exp_run});
    rd(2'd3, v);
    expect_eq(req, "timer", v, exp_cnt);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check_state("R1", 1'b0, 0);
    rd(2'd2, v); expect_eq("R1", "prescaler", v, 0);
    rd(2'd0, v); expect_eq("R2", "control read", v, 0);
  endtask

  task automatic t_idle_load;
    logic [31:0] v;
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, 32'h1234_5678);
    rd(2'd2, v); expect_eq("R2", "prescaler load", v, 32'hDEAD_BEEF);
    rd(2'd3, v); expect_eq("R2", "timer load", v, 32'h1234_5678);
    expect_eq("R2", "still idle", {31'b0, running}, 0);
  endtask

  task automatic t_period2;
    wr(2'd2, 2); wr(2'd3, 3);
    wr(2'd0, 0);
    check_state("R3", 1'b1, 3);
    wait_edges(2); check_state("R9", 1'b1, 3);
    wait_edges(1); check_state("R6", 1'b1, 2);
    wait_edges(3); check_state("R6", 1'b1, 1);
    wait_edges(2); check_state("R9", 1'b1, 1);
    wait_edges(1); check_state("R7", 1'b0, 0);
    wait_edges(3); check_state("R7", 1'b0, 0);
  endtask

  task automatic t_period0;
    wr(2'd2, 0); wr(2'd3, 4);
    wr(2'd0, 32'hFFFF_FFFF);
    check_state("R3", 1'b1, 4);
    wait_edges(1); check_state("R6", 1'b1, 3);
    wait_edges(2); check_state("R6", 1'b1, 1);
    wait_edges(1); check_state("R7", 1'b0, 0);
  endtask

  task automatic t_stop;
    wr(2'd2, 1); wr(2'd3, 10);
    wr(2'd0, 1);
    wait_edges(5); check_state("R6", 1'b1, 8);
    wr(2'd0, 5);
    check_state("R4", 1'b0, 8);
    wait_edges(5); check_state("R4", 1'b0, 8);
    wr(2'd3, 20); check_state("R4", 1'b0, 20);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    wr(2'd2, 5); wr(2'd3, 7);
    wr(2'd0, 0);
    wr(2'd2, 99); wr(2'd3, 99);
    rd(2'd2, v); expect_eq("R5", "prescaler locked", v, 5);
    check_state("R5", 1'b1, 7);
    wr(2'd0, 0);
    check_state("R5", 1'b0, 7);
  endtask

  task automatic t_zero_start;
    wr(2'd3, 0);
    wr(2'd0, 0);
    check_state("R8", 1'b1, 0);
    wait_edges(1); check_state("R8", 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_load();
    t_period2();
    t_period0();
    t_stop();
    t_locked();
    t_zero_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule